// File: doc/BRIEF.md
# Dual-Phase Duty Generator with Mode Transition

This block drives two interleaved power phases from a single shared sawtooth ramp. A fixed-frequency ramp clock is divided into two alternating start strobes, one per phase, so each phase switches at half the ramp rate. One comparator output tells the block where the ramp crosses the control level. Each duty output rises at its own phase start, and a comparator rising edge ends it.

Two operating modes exist. In the low-duty mode each duty ends on the ramp on which it began. When a duty is still high as the other phase starts, the duty has passed 50 %. The block raises an overflow pulse and enters the high-duty mode. In that mode a duty skips the comparator edge of its own start ramp and ends on the first edge after the other phase has started, so it can span more than one ramp. The way ramps map to phases is therefore swapped between the modes. The block returns to the low-duty mode only after a run of consecutive early endings, each falling within a guard window after the ramp start. A single noisy edge cannot flip the mode back. An enable input can lock the block in the low-duty mode.

All inputs are synchronised to a fast system clock and edge-detected. All outputs are registered.

Top module: `dual_duty_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, both duties, both strobes and both overflow flags are 0 and the mode flag is 1 (low-duty mode). The first ramp clock rise after reset starts phase A.
- R2: Each ramp clock rising edge produces a one-cycle strobe, and the strobes alternate A, B, A, B. A strobe and the duty it sets appear SYNC_STAGES+1 system cycles after the ramp clock input rises. The two strobes are never high together.
- R3: Duty A goes high only in the cycle of strobe A, and duty B only in the cycle of strobe B.
- R4: In low-duty mode (mode flag 1), a comparator rising edge clears the duty of the phase that owns the current ramp.
- R5: In low-duty mode, when duty A is still high at strobe B, overflow A pulses in the same cycle as strobe B. When duty B is still high at strobe A, overflow B pulses in the same cycle as strobe A. If enabled, the mode flag goes to 0 in that same cycle. Overflow never pulses in high-duty mode.
- R6: In high-duty mode (mode flag 0), a comparator rising edge clears the duty started on the previous ramp. The duty that started on the current ramp ignores that edge.
- R7: In high-duty mode, a clearing comparator edge is early when it comes at most GUARD_CYC cycles after the ramp start. EXIT_CNT consecutive early clears return the mode flag to 1 and clear both duties. A clear that is not early restarts the count.
- R8: With the mode enable low, the mode flag stays 1. Overflow pulses are still reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ramp_clk_i | input | 1 | Fixed-frequency ramp clock (asynchronous) |
| pwm_i | input | 1 | Shared comparator output (asynchronous) |
| mode_en_i | input | 1 | 1 allows mode transitions; 0 holds low-duty mode |
| duty_a_o | output | 1 | Phase A duty signal |
| duty_b_o | output | 1 | Phase B duty signal |
| strobe_a_o | output | 1 | Phase A start strobe, one cycle |
| strobe_b_o | output | 1 | Phase B start strobe, one cycle |
| ovf_a_o | output | 1 | Duty A passed the start of phase B in low-duty mode |
| ovf_b_o | output | 1 | Duty B passed the start of phase A in low-duty mode |
| mode_low_o | output | 1 | 1 in low-duty mode, 0 in high-duty mode |

## Verification
The bench builds the block with SYNC_STAGES=2, GUARD_CYC=8 and EXIT_CNT=2. With these values the guard window is short against a 40-cycle ramp, so comparator offsets of 3 (early) and 20 (late) fall on clearly different sides of it. An exit needs only two early clears, so a short run shows both the exit and the hysteresis. A late clear placed between two early ones proves that the count restarts. A ramp with no comparator edge forces the overflow and the entry into the high-duty mode. The same stimulus is then repeated with the enable low.

// File: rtl/dd_pkg.sv
package dd_pkg;
  typedef enum logic {PH_A = 1'b0, PH_B = 1'b1} phase_e;
endpackage

// File: rtl/dd_edge_sync.sv
module dd_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) sync_q[0] <= 1'b0;
          else     sync_q[0] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) sync_q[g] <= 1'b0;
          else     sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b0;
    else     last_q <= sync_q[STAGES-1];
  end

  assign rise_o = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/dd_phase_div.sv
module dd_phase_div
  import dd_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   tick_i,
  output logic   next_b_o,
  output phase_e cur_o,
  output logic   strobe_a_o,
  output logic   strobe_b_o
);
  logic   sel_q;
  phase_e cur_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q      <= 1'b0;
      cur_q      <= PH_A;
      strobe_a_o <= 1'b0;
      strobe_b_o <= 1'b0;
    end else begin
      strobe_a_o <= tick_i & ~sel_q;
      strobe_b_o <= tick_i & sel_q;
      if (tick_i) begin
        sel_q <= ~sel_q;
        cur_q <= sel_q ? PH_B : PH_A;
      end
    end
  end

  assign next_b_o = sel_q;
  assign cur_o    = cur_q;
endmodule

// File: rtl/dd_mode_fsm.sv
module dd_mode_fsm #(
  parameter int GUARD_CYC = 16,
  parameter int EXIT_CNT  = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic mode_en_i,
  input  logic tick_i,
  input  logic tick_b_i,
  input  logic duty_a_i,
  input  logic duty_b_i,
  input  logic clr_hit_i,
  output logic mode_low_o,
  output logic exit_o,
  output logic ovf_a_o,
  output logic ovf_b_o
);
  localparam int CW = $clog2(GUARD_CYC + 1);
  localparam int EW = $clog2(EXIT_CNT + 1);
  localparam logic [CW-1:0] GUARD_V = CW'(GUARD_CYC);
  localparam logic [EW-1:0] LAST_V  = EW'(EXIT_CNT - 1);

  logic [CW-1:0] cnt_q;
  logic [EW-1:0] shorts_q;
  logic          early;
  logic          pass_other;

  assign early      = cnt_q < GUARD_V;
  assign pass_other = tick_i & (tick_b_i ? duty_a_i : duty_b_i);
  assign exit_o     = mode_en_i & ~mode_low_o & clr_hit_i & early & (shorts_q == LAST_V);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_low_o <= 1'b1;
      cnt_q      <= '0;
      shorts_q   <= '0;
      ovf_a_o    <= 1'b0;
      ovf_b_o    <= 1'b0;
    end else begin
      ovf_a_o <= tick_i & tick_b_i & mode_low_o & duty_a_i;
      ovf_b_o <= tick_i & ~tick_b_i & mode_low_o & duty_b_i;
      if (tick_i)              cnt_q <= '0;
      else if (cnt_q < GUARD_V) cnt_q <= cnt_q + 1'b1;
      if (!mode_en_i) begin
        mode_low_o <= 1'b1;
        shorts_q   <= '0;
      end else if (mode_low_o) begin
        shorts_q <= '0;
        if (pass_other) mode_low_o <= 1'b0;
      end else if (clr_hit_i) begin
        if (!early)      shorts_q <= '0;
        else if (exit_o) begin
          mode_low_o <= 1'b1;
          shorts_q   <= '0;
        end else         shorts_q <= shorts_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/dual_duty_ctrl.sv
module dual_duty_ctrl
  import dd_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int GUARD_CYC   = 16,
  parameter int EXIT_CNT    = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic ramp_clk_i,
  input  logic pwm_i,
  input  logic mode_en_i,
  output logic duty_a_o,
  output logic duty_b_o,
  output logic strobe_a_o,
  output logic strobe_b_o,
  output logic ovf_a_o,
  output logic ovf_b_o,
  output logic mode_low_o
);
  logic   tick, pwm_rise, next_b, exit_hit, clr_hit;
  logic   clr_a, clr_b, set_a, set_b;
  phase_e cur, tgt;

  dd_edge_sync #(.STAGES(SYNC_STAGES)) u_ramp_sync (
    .clk(clk), .rst(rst), .async_i(ramp_clk_i), .rise_o(tick));
  dd_edge_sync #(.STAGES(SYNC_STAGES)) u_pwm_sync (
    .clk(clk), .rst(rst), .async_i(pwm_i), .rise_o(pwm_rise));

  dd_phase_div u_div (
    .clk(clk), .rst(rst), .tick_i(tick), .next_b_o(next_b), .cur_o(cur),
    .strobe_a_o(strobe_a_o), .strobe_b_o(strobe_b_o));

  // Low-duty mode clears the owner of the current ramp; high-duty mode the previous one.
  assign tgt     = mode_low_o ? cur : ((cur == PH_A) ? PH_B : PH_A);
  assign clr_a   = pwm_rise & (tgt == PH_A);
  assign clr_b   = pwm_rise & (tgt == PH_B);
  assign clr_hit = (clr_a & duty_a_o) | (clr_b & duty_b_o);
  assign set_a   = tick & ~next_b;
  assign set_b   = tick & next_b;

  dd_mode_fsm #(.GUARD_CYC(GUARD_CYC), .EXIT_CNT(EXIT_CNT)) u_mode (
    .clk(clk), .rst(rst), .mode_en_i(mode_en_i), .tick_i(tick),
    .tick_b_i(next_b), .duty_a_i(duty_a_o), .duty_b_i(duty_b_o),
    .clr_hit_i(clr_hit), .mode_low_o(mode_low_o), .exit_o(exit_hit),
    .ovf_a_o(ovf_a_o), .ovf_b_o(ovf_b_o));

  always_ff @(posedge clk) begin
    if (rst) begin
      duty_a_o <= 1'b0;
      duty_b_o <= 1'b0;
    end else begin
      if (set_a)                 duty_a_o <= 1'b1;
      else if (clr_a | exit_hit) duty_a_o <= 1'b0;
      if (set_b)                 duty_b_o <= 1'b1;
      else if (clr_b | exit_hit) duty_b_o <= 1'b0;
    end
  end
endmodule

// File: rtl/dd_chk.sv
module dd_chk (
  input logic clk,
  input logic rst,
  input logic mode_en_i,
  input logic duty_a_o,
  input logic duty_b_o,
  input logic strobe_a_o,
  input logic strobe_b_o,
  input logic ovf_a_o,
  input logic ovf_b_o,
  input logic mode_low_o
);
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(strobe_a_o && strobe_b_o)); // R2
  AST_SET_A_AT_STROBE: assert property (@(posedge clk) disable iff (rst)
    $rose(duty_a_o) |-> strobe_a_o); // R3
  AST_SET_B_AT_STROBE: assert property (@(posedge clk) disable iff (rst)
    $rose(duty_b_o) |-> strobe_b_o); // R3
  AST_OVF_A_AT_B: assert property (@(posedge clk) disable iff (rst)
    ovf_a_o |-> strobe_b_o && duty_a_o); // R5
  AST_OVF_B_AT_A: assert property (@(posedge clk) disable iff (rst)
    ovf_b_o |-> strobe_a_o && duty_b_o); // R5
  AST_OVF_ONLY_LOW: assert property (@(posedge clk) disable iff (rst)
    (ovf_a_o || ovf_b_o) |-> $past(mode_low_o)); // R5
  AST_OVF_ENTERS_HIGH: assert property (@(posedge clk) disable iff (rst)
    ((ovf_a_o || ovf_b_o) && $past(mode_en_i)) |-> !mode_low_o); // R5
  AST_DISABLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    $past(!mode_en_i) |-> mode_low_o); // R8
endmodule

bind dual_duty_ctrl dd_chk u_dd_chk (
  .clk(clk), .rst(rst), .mode_en_i(mode_en_i), .duty_a_o(duty_a_o),
  .duty_b_o(duty_b_o), .strobe_a_o(strobe_a_o), .strobe_b_o(strobe_b_o),
  .ovf_a_o(ovf_a_o), .ovf_b_o(ovf_b_o), .mode_low_o(mode_low_o));

// File: tb/dual_duty_ctrl_tb_top.sv
module dual_duty_ctrl_tb_top;
  localparam int GUARD = 8;
  localparam int EXITN = 2;
  localparam int RAMP  = 40;

  logic clk = 1'b0, rst = 1'b1, ramp_clk = 1'b0, pwm = 1'b0, en = 1'b1;
  logic da, db, sa, sb, oa, ob, ml;
  int   n_run = 0, n_fail = 0;
  logic [5:0] exp_q[$];

  // model state
  bit m_sel, m_cur, m_da, m_db, m_ml = 1'b1;
  int m_sh;

  always #5 clk = ~clk;

  dual_duty_ctrl #(.SYNC_STAGES(2), .GUARD_CYC(GUARD), .EXIT_CNT(EXITN)) dut_i (
    .clk(clk), .rst(rst), .ramp_clk_i(ramp_clk), .pwm_i(pwm), .mode_en_i(en),
    .duty_a_o(da), .duty_b_o(db), .strobe_a_o(sa), .strobe_b_o(sb),
    .ovf_a_o(oa), .ovf_b_o(ob), .mode_low_o(ml));

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: one expected snapshot {is_b, duty_a, duty_b, ovf_a, ovf_b, mode} per strobe
  always @(negedge clk) begin
    if (!rst && (sa || sb)) begin
      if (exp_q.size() == 0) chk("R2 unexpected strobe", 8'(sb), 8'hff);
      else chk("R2/R3/R4/R5/R6/R7/R8 strobe snapshot",
               8'({sb, da, db, oa, ob, ml}), 8'(exp_q.pop_front()));
    end
  end

  // driver: one ramp; p < 0 means no comparator edge in this ramp
  task automatic ramp(int p, bit lat_chk);
    bit oa_e, ob_e;
    oa_e = 1'b0; ob_e = 1'b0;
    if (!m_sel) begin
      ob_e = m_ml & m_db;
      if (ob_e && en) m_ml = 1'b0;
      m_da = 1'b1; m_cur = 1'b0;
    end else begin
      oa_e = m_ml & m_da;
      if (oa_e && en) m_ml = 1'b0;
      m_db = 1'b1; m_cur = 1'b1;
    end
    if (!en) m_ml = 1'b1;
    exp_q.push_back({m_sel, m_da, m_db, oa_e, ob_e, m_ml});
    m_sel = ~m_sel;
    if (p >= 0) begin
      bit tgt, hit;
      tgt = m_ml ? m_cur : ~m_cur;
      hit = tgt ? m_db : m_da;
      if (hit) begin
        if (tgt) m_db = 1'b0; else m_da = 1'b0;
        if (!m_ml) begin
          if (p - 1 < GUARD) begin
            m_sh++;
            if (m_sh == EXITN) begin m_ml = 1'b1; m_sh = 0; m_da = 1'b0; m_db = 1'b0; end
          end else m_sh = 0;
        end
      end
    end
    if (m_ml) m_sh = 0;
    @(negedge clk);
    ramp_clk = 1'b1;
    for (int i = 1; i < RAMP; i++) begin
      @(negedge clk);
      if (lat_chk && i == 2) chk("R2 latency before", 8'({sa, da}), 8'h0);
      if (lat_chk && i == 3) chk("R2 latency at", 8'({sa, da}), 8'h3);
      if (i == 10) ramp_clk = 1'b0;
      if (p >= 0 && i == p) pwm = 1'b1;
      if (i == RAMP - 2) pwm = 1'b0;
    end
  endtask

  initial begin
    repeat (120000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk("R1 reset outputs", 8'({da, db, sa, sb, oa, ob, ml}), 8'h01);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after reset", 8'({da, db, sa, sb, oa, ob, ml}), 8'h01);
    // R1 R2 R3 R4: low-duty mode, phase A first, each duty cleared in its own ramp
    ramp(15, 1'b1);
    chk("R4 duty A cleared in own ramp", 8'({da, db}), 8'h0);
    ramp(15, 1'b0); ramp(15, 1'b0); ramp(15, 1'b0);
    // R5: missing comparator edge on phase A ramp -> overflow at strobe B
    ramp(-1, 1'b0);
    ramp(20, 1'b0);
    // R6: high-duty mode, late clears keep the mode
    ramp(20, 1'b0); ramp(20, 1'b0); ramp(20, 1'b0);
    // R7: early, late, early keeps the mode; a second early in a row exits
    ramp(3, 1'b0); ramp(20, 1'b0); ramp(3, 1'b0); ramp(3, 1'b0);
    chk("R7 exit clears both duties", 8'({da, db, ml}), 8'h1);
    ramp(15, 1'b0); ramp(15, 1'b0);
    // R8: transitions disabled, overflow still flagged
    en = 1'b0;
    ramp(-1, 1'b0); ramp(15, 1'b0); ramp(15, 1'b0); ramp(15, 1'b0);
    chk("R8 mode held low-duty", 8'(ml), 8'h1);
    en = 1'b1;
    ramp(15, 1'b0); ramp(15, 1'b0);
    repeat (4) @(negedge clk);
    chk("R2 all snapshots consumed", 8'(exp_q.size()), 8'h0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule